// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block holds the program counter of a small processor and fetches one 16-bit instruction word per clock from a byte-addressed program memory. The address it presents is always even, and it moves forward one word (two bytes) at a time. Memory returns the word at that address on `imem_rdata_i` in the same cycle, with the low byte taken from the even byte address and the high byte from the odd address above it. The sequencer resolves jumps on its own: absolute jumps and calls carry a 20-bit word target, and relative branches carry a signed offset counted in words. The next fetch therefore already comes from the target address.

A few opcodes take two words. When the sequencer sees one of them, it holds the first word for one cycle and fetches the second. It then hands both to the execute stage as a single retired instruction, with the operand bits of the two words joined. The execute stage may ask for the next fetched word to be skipped after a conditional test. A skipped word retires as the all-zero no-op word. If the skipped word was the first half of a two-word instruction, its second half carries a 1111 prefix and simply retires on its own as a no-op word.

Top module: `fetch_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `imem_addr_o` is 0x000000, `ret_valid_o` is 0 and `pending_o` is 0.
- R2: A plain word fetched at address A with `skip_i` low makes the next address A+2, modulo 2^21. In the following cycle it retires with `ret_valid_o`=1, `ret_word_o` equal to that word and `ret_ext_o`=0. `imem_addr_o` bit 0 is always 0.
- R3: The two-word opcodes are as follows. Goto has bits [15:8]=0xEF. Call has bits [15:9]=1110110. Register move has bits [15:12]=0xC. Pointer load has bits [15:6]=1110111000. An unskipped first word of one of these retires nothing in the next cycle, and `pending_o` is high in that cycle while the address moves on by 2.
- R4: For goto and call, the word target is {second[11:0], first[7:0]}. The address after the second word is target*2, and `ret_ext_o` is {4'b0, target}. The words 0xEF03 then 0xF000 lead to address 0x000006.
- R5: For move and pointer load, `ret_ext_o` is {first[11:0], second[11:0]} and the address continues sequentially.
- R6: A word with bits [15:11]=11010 is a relative branch with a signed 11-bit word offset in bits [10:0]. Fetched at A, it makes the next address A+2+2*offset, modulo 2^21, and it retires as a plain word.
- R7: `skip_i` high in a cycle where `pending_o` is low squashes the word fetched in that cycle. The word retires next cycle with `ret_word_o`=0x0000 and `ret_ext_o`=0, and it causes no branch, no jump and no pending state.
- R8: When the first word of a two-word instruction is squashed, its 0xF-prefixed second word is fetched as an ordinary word and retires as itself, and the address keeps stepping by 2.
- R9: `skip_i` is ignored while `pending_o` is high. The two-word instruction still retires whole and still jumps.
- R10: `pending_o` never stays high for two cycles in a row. A two-word instruction retires with `ret_word_o` equal to its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 21 | Byte address of the word being fetched |
| imem_rdata_i | input | 16 | Instruction word at `imem_addr_o` |
| skip_i | input | 1 | Squash the word fetched this cycle |
| pending_o | output | 1 | Second word of a two-word instruction is being fetched |
| ret_valid_o | output | 1 | An instruction retires this cycle |
| ret_word_o | output | 16 | Retired word, or first word of a two-word instruction |
| ret_ext_o | output | 24 | Joined operand of a two-word instruction, else 0 |

## Verification
The assertions assume that memory is well formed. Whenever `pending_o` is high, the word on `imem_rdata_i` is a second word with a 1111 prefix, and the prefix check is written as a property about that input. Every program in the stimulus places a 0xF-prefixed word right after each two-word first word that is not skipped. The sweeps also force a reset before the sequencer can reach any word that aliases into an unplanned part of the modelled memory. Skip pulses are placed both in ordinary fetch cycles and in the pending cycle, so that the honoured case and the ignored case are both reached.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [2:0] {
    CL_PLAIN,
    CL_BRANCH,
    CL_GOTO,
    CL_CALL,
    CL_MOVE,
    CL_LDPTR
  } word_class_e;

  function automatic logic is_two_word(word_class_e c);
    return (c == CL_GOTO) || (c == CL_CALL) || (c == CL_MOVE) || (c == CL_LDPTR);
  endfunction

  function automatic logic is_jump(word_class_e c);
    return (c == CL_GOTO) || (c == CL_CALL);
  endfunction
endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
  import fseq_pkg::*;
#(
  parameter int OPC_W = 10
) (
  input  logic [OPC_W-1:0] op_i,
  output word_class_e      cls_o
);
  always_comb begin
    cls_o = CL_PLAIN;
    if (op_i[OPC_W-1 -: 4] == 4'hC)              cls_o = CL_MOVE;
    else if (op_i[OPC_W-1 -: 5] == 5'b11010)     cls_o = CL_BRANCH;
    else if (op_i[OPC_W-1 -: 8] == 8'hEF)        cls_o = CL_GOTO;
    else if (op_i[OPC_W-1 -: 7] == 7'b1110110)   cls_o = CL_CALL;
    else if (op_i[OPC_W-1 -: 10] == 10'b1110111000) cls_o = CL_LDPTR;
  end
endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
  parameter int PC_W  = 21,
  parameter int OFS_W = 11,
  localparam int TGT_W = PC_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             jmp_i,
  input  logic             br_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [PC_W-1:0]  pc_o
);
  logic [PC_W-1:0] pc_q, pc_d, step;

  // word offset scaled to bytes
  assign step = br_i ? {{(PC_W-OFS_W-1){ofs_i[OFS_W-1]}}, ofs_i, 1'b0} : '0;

  always_comb begin
    if (jmp_i) pc_d = {tgt_i, 1'b0};
    else       pc_d = pc_q + PC_W'(2) + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  AST_PC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[0] == 1'b0); // R2
endmodule

// File: rtl/fseq_operand.sv
module fseq_operand #(
  parameter int ARG_W = 12,
  parameter int TGT_W = 20,
  localparam int EXT_W = 2 * ARG_W,
  localparam int LOW_W = TGT_W - ARG_W
) (
  input  logic [ARG_W-1:0] first_i,
  input  logic [ARG_W-1:0] second_i,
  input  logic             jump_i,
  output logic [EXT_W-1:0] ext_o
);
  always_comb begin
    if (jump_i) ext_o = {{(EXT_W-TGT_W){1'b0}}, second_i, first_i[LOW_W-1:0]};
    else        ext_o = {first_i, second_i};
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fseq_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int WORD_W = 16,
  parameter int OFS_W  = 11,
  localparam int ARG_W = WORD_W - 4,
  localparam int EXT_W = 2 * ARG_W,
  localparam int TGT_W = PC_W - 1,
  localparam int LOW_W = TGT_W - ARG_W,
  localparam int OPC_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PC_W-1:0]   imem_addr_o,
  input  logic [WORD_W-1:0] imem_rdata_i,
  input  logic              skip_i,
  output logic              pending_o,
  output logic              ret_valid_o,
  output logic [WORD_W-1:0] ret_word_o,
  output logic [EXT_W-1:0]  ret_ext_o
);
  logic              pending_q;
  logic [WORD_W-1:0] first_q;
  word_class_e       cur_cls, first_cls;
  logic              squash, take_br, take_jmp;
  logic [EXT_W-1:0]  ext;
  logic [TGT_W-1:0]  tgt;

  fseq_decode #(.OPC_W(OPC_W)) i_dec_cur (
    .op_i  (imem_rdata_i[WORD_W-1 -: OPC_W]),
    .cls_o (cur_cls)
  );

  fseq_decode #(.OPC_W(OPC_W)) i_dec_first (
    .op_i  (first_q[WORD_W-1 -: OPC_W]),
    .cls_o (first_cls)
  );

  assign squash   = skip_i & ~pending_q;
  assign take_br  = ~pending_q & ~squash & (cur_cls == CL_BRANCH);
  assign take_jmp = pending_q & is_jump(first_cls);
  assign tgt      = {imem_rdata_i[ARG_W-1:0], first_q[LOW_W-1:0]};

  fseq_pc #(.PC_W(PC_W), .OFS_W(OFS_W)) i_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .jmp_i  (take_jmp),
    .br_i   (take_br),
    .ofs_i  (imem_rdata_i[OFS_W-1:0]),
    .tgt_i  (tgt),
    .pc_o   (imem_addr_o)
  );

  fseq_operand #(.ARG_W(ARG_W), .TGT_W(TGT_W)) i_opnd (
    .first_i  (first_q[ARG_W-1:0]),
    .second_i (imem_rdata_i[ARG_W-1:0]),
    .jump_i   (is_jump(first_cls)),
    .ext_o    (ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q   <= 1'b0;
      first_q     <= '0;
      ret_valid_o <= 1'b0;
      ret_word_o  <= '0;
      ret_ext_o   <= '0;
    end else if (pending_q) begin
      pending_q   <= 1'b0;
      ret_valid_o <= 1'b1;
      ret_word_o  <= first_q;
      ret_ext_o   <= ext;
    end else if (squash) begin
      ret_valid_o <= 1'b1;
      ret_word_o  <= '0;
      ret_ext_o   <= '0;
    end else if (is_two_word(cur_cls)) begin
      pending_q   <= 1'b1;
      first_q     <= imem_rdata_i;
      ret_valid_o <= 1'b0;
    end else begin
      ret_valid_o <= 1'b1;
      ret_word_o  <= imem_rdata_i;
      ret_ext_o   <= '0;
    end
  end

  assign pending_o = pending_q;

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_q && !skip_i && cur_cls == CL_PLAIN) |=> imem_addr_o == $past(imem_addr_o) + PC_W'(2)); // R2
  AST_PEND_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q |-> !ret_valid_o); // R3
  AST_SECOND_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q |-> imem_rdata_i[WORD_W-1 -: 4] == 4'hF); // R3
  AST_JUMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && is_jump(first_cls)) |=>
      imem_addr_o == {$past(imem_rdata_i[ARG_W-1:0]), $past(first_q[LOW_W-1:0]), 1'b0}); // R4
  AST_SQUASH_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_q && skip_i) |=> (ret_valid_o && ret_word_o == '0 && ret_ext_o == '0 && !pending_q)); // R7
  AST_SKIP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && skip_i) |=> (ret_valid_o && ret_word_o == $past(first_q))); // R9
  AST_PEND_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q |=> !pending_q); // R10
endmodule

// File: tb/test_fetch_seq.sv
module test_fetch_seq;
  localparam int CLK_P = 10;

  logic        clk, rst_ni, skip;
  logic [20:0] addr;
  logic [15:0] rdata;
  logic        pend, rvalid;
  logic [15:0] rword;
  logic [23:0] rext;
  logic [15:0] mem [0:2047];
  int vectors = 0, errors = 0;
  bit done = 0;

  assign rdata = mem[addr[11:1]];

  fetch_seq i_fetch_seq (
    .clk_i(clk), .rst_ni(rst_ni), .imem_addr_o(addr), .imem_rdata_i(rdata),
    .skip_i(skip), .pending_o(pend), .ret_valid_o(rvalid),
    .ret_word_o(rword), .ret_ext_o(rext)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic restart();
    rst_ni = 1'b0;
    skip   = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 2048; k++) mem[k] = 16'h0000;
  endtask

  initial begin
    rst_ni = 1'b0;
    skip   = 1'b0;
    clear_mem();
    // R1 reset state, during and just after reset
    @(negedge clk);
    chk("R1 addr in reset", 32'(addr), 0);
    chk("R1 valid in reset", 32'(rvalid), 0);
    restart();
    chk("R1 addr", 32'(addr), 0);
    chk("R1 valid", 32'(rvalid), 0);
    chk("R1 pending", 32'(pend), 0);

    // R2 plain stepping
    for (int k = 0; k < 64; k++) mem[k] = 16'h1000 + 16'(k);
    restart();
    for (int n = 1; n <= 40; n++) begin
      tick();
      chk("R2 addr step", 32'(addr), 32'(2 * n));
      chk("R2 word", 32'(rword), 32'(16'h1000 + 16'(n - 1)));
      chk("R2 ext", 32'(rext), 0);
      chk("R2 valid", 32'(rvalid), 1);
    end

    // R4 goto/call target sweep (walking ones, all ones, fixed example)
    for (int i = 0; i < 22; i++) begin
      logic [19:0] t;
      logic [7:0]  op;
      t  = (i < 20) ? 20'(1 << i) : ((i == 20) ? 20'hFFFFF : 20'h00003);
      op = (i % 3 == 0) ? 8'hEF : ((i % 3 == 1) ? 8'hEC : 8'hED);
      if (i == 21) op = 8'hEF;
      clear_mem();
      mem[0] = {op, t[7:0]};
      mem[1] = {4'hF, t[19:8]};
      restart();
      tick();
      chk("R3 pending", 32'(pend), 1);
      chk("R3 no retire", 32'(rvalid), 0);
      chk("R3 addr", 32'(addr), 2);
      tick();
      chk("R4 target addr", 32'(addr), 32'({t, 1'b0}));
      chk("R4 ext", 32'(rext), 32'(t));
      chk("R10 word", 32'(rword), 32'({op, t[7:0]}));
      chk("R10 pending drop", 32'(pend), 0);
      if (t == 20'hFFFFF) begin
        tick();
        chk("R2 wrap", 32'(addr), 0);
      end
    end

    // R5 move and pointer load operands
    clear_mem();
    mem[0] = 16'hC123; mem[1] = 16'hF456;
    mem[2] = 16'hEE1A; mem[3] = 16'hF0BC;
    mem[4] = 16'h0F55;
    restart();
    tick();
    chk("R3 move pending", 32'(pend), 1);
    tick();
    chk("R5 move ext", 32'(rext), 32'h123456);
    chk("R5 move word", 32'(rword), 32'hC123);
    chk("R5 move addr", 32'(addr), 4);
    tick();
    chk("R3 ldptr pending", 32'(pend), 1);
    tick();
    chk("R5 ldptr ext", 32'(rext), 32'hE1A0BC);
    chk("R5 ldptr addr", 32'(addr), 8);
    tick();
    chk("R2 after pair", 32'(rword), 32'h0F55);
    chk("R2 ext zero", 32'(rext), 0);

    // R6 exhaustive branch offset sweep, branch at byte 0x200
    for (int off = 0; off < 2048; off++) begin
      int v;
      v = (off >= 1024) ? off - 2048 : off;
      mem[0] = 16'hEF00; mem[1] = 16'hF001;
      mem[16'h100] = 16'hD000 | 16'(off);
      restart();
      tick();
      tick();
      if (off == 0) chk("R4 goto 0x200", 32'(addr), 32'h200);
      tick();
      chk("R6 branch target", 32'(addr), (32'h202 + 2 * v) & 32'h1FFFFF);
      if (off == 5) chk("R6 branch retires", 32'(rword), 32'hD005);
    end

    // R7/R8 skip of a goto first word, then of a branch
    clear_mem();
    mem[0] = 16'h1111; mem[1] = 16'hEF05; mem[2] = 16'hF000;
    mem[3] = 16'h2222; mem[4] = 16'hD005; mem[5] = 16'h3333;
    restart();
    tick();
    chk("R2 first", 32'(rword), 32'h1111);
    skip = 1'b1;
    tick();
    skip = 1'b0;
    chk("R7 squash word", 32'(rword), 0);
    chk("R7 squash valid", 32'(rvalid), 1);
    chk("R7 no pending", 32'(pend), 0);
    chk("R7 no jump", 32'(addr), 4);
    tick();
    chk("R8 orphan word", 32'(rword), 32'hF000);
    chk("R8 orphan ext", 32'(rext), 0);
    chk("R8 addr", 32'(addr), 6);
    tick();
    chk("R2 after orphan", 32'(rword), 32'h2222);
    skip = 1'b1;
    tick();
    skip = 1'b0;
    chk("R7 squashed branch word", 32'(rword), 0);
    chk("R7 squashed branch addr", 32'(addr), 32'hA);

    // R9 skip during pending cycle is ignored
    clear_mem();
    mem[0] = 16'hEF05; mem[1] = 16'hF000;
    restart();
    tick();
    skip = 1'b1;
    tick();
    skip = 1'b0;
    chk("R9 jump kept", 32'(addr), 32'hA);
    chk("R9 word kept", 32'(rword), 32'hEF05);
    chk("R9 ext kept", 32'(rext), 5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule